// File: doc/BRIEF.md
# Peripheral Bus Timing Sequencer

The sequencer runs one read or one write at a time on a multiplexed peripheral bus. The bus has one shared address/data path, an address latch enable, an active-low chip select, an active-low output enable and an active-low write strobe. A request comes in on a valid/ready handshake and carries a region index, a direction, an address and write data. The block sends the address in a single latch-enable cycle. It then asserts chip select and paces the strobe edges with the timing word of the addressed region. It releases the bus and returns read data with a one-cycle done pulse. Before it takes the next request, it holds the bus idle for a programmable number of cycles.

The block stores eight timing words, one for each region. A single configuration write replaces a whole word. When a region has acknowledge mode on, a ready input can end the strobe before its programmed length. That input normally passes through a synchronizer chain. A per-region bit bypasses the chain, so the acknowledge takes effect sooner. The block also flags each region whose output-enable delay is not shorter than its chip-select width.

The control is one state machine with six states:
- ST_IDLE accepts a request and moves to ST_ALE.
- ST_ALE lasts one cycle. It moves to ST_SETUP when the lead delay is nonzero, and to ST_STRB otherwise.
- ST_SETUP counts down the lead delay and then moves to ST_STRB.
- ST_STRB ends when its count expires or an acknowledge is seen. It moves to ST_RELS when a release gap applies. Otherwise it finishes.
- ST_RELS counts the release gap and then finishes.
- Finishing moves to ST_GAP when the idle count is nonzero, and to ST_IDLE otherwise.
- ST_GAP counts down and then moves to ST_IDLE.

Top module: `pbseq_top`

## Requirements
- R1: After reset, the block behaves as follows:
  - req_ready is 1 and all bus strobes are inactive.
  - Region 0 has ale-to-write 7, write width 7 and idle 6.
  - Regions 1 to 7 have 1, 1 and 1 for those fields.
  - Every region has CS-to-OE 0, release 0, CS width 3, ready bypass 0 and acknowledge 0.
- R2: A configuration write replaces every field of the selected region's word at the next clock edge. It leaves the other regions unchanged. The word layout is [2:0] ale-to-write, [6:3] write width, [10:7] idle, [12:11] CS-to-OE, [14:13] release gap, [16:15] CS width, [17] ready bypass, [18] acknowledge enable.
- R3: A write behaves as follows:
  - bus_ale is high for exactly one cycle, with the address on bus_ad_o, and this is the cycle after acceptance.
  - Chip select goes low in the next cycle.
  - The write strobe asserts ale-to-write cycles after that.
  - The strobe lasts max(write width,1) cycles, with the write data driven.
- R4: A read behaves as follows:
  - Output enable asserts CS-to-OE cycles after chip select.
  - It lasts CS width minus CS-to-OE cycles, or 1 cycle when that difference is not positive.
  - bus_ad_i is captured in the last output-enable cycle and returned on rsp_rdata with rsp_done.
- R5: Chip select stays low for release-gap cycles after the strobe ends. This applies to reads, and to writes in acknowledge mode. Other writes get no gap. rsp_done pulses in the first cycle after chip select rises.
- R6: The done cycle starts the idle window. req_ready stays low for exactly idle cycles, counted from the done cycle.
- R7: In acknowledge mode, the strobe ends at the clock edge where the effective ready is high during a strobe cycle, or at its programmed length if that comes first.
- R8: With ready bypass 1, a ready that rises during strobe cycle k ends the strobe after k+1 cycles. With bypass 0, the two-flop synchronizer delays this to k+3 cycles.
- R9: Ready has no effect when acknowledge mode is off, or when it is high only outside strobe cycles.
- R10: cfg_err[i] is 1 exactly when region i's CS-to-OE value is greater than or equal to its CS width.
- R11: The block takes no request while a transfer is in progress. A transfer uses the timing word its region held at acceptance, even if that word is rewritten during the transfer.
- R12: The output enable and the write strobe are never active together. Either strobe is active only while chip select is low. The shared bus is not driven while output enable is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing word write enable |
| cfg_sel | input | 3 | Region whose word is written |
| cfg_wdata | input | 19 | New timing word |
| cfg_err | output | 8 | Per-region invalid OE delay flag |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_region | input | 3 | Region of the request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_ad_o | output | 16 | Address/data driven onto the bus |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | 16 | Data read from the bus |
| bus_rdy | input | 1 | Ready acknowledge from the peripheral |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in one chosen strobe cycle. To create it, a bench monitor watches the strobes on the falling edge and raises ready exactly in strobe cycle k. It does this for both the synchronized and the bypassed path, for several values of k, and in both directions. The early-end length is then compared against k+1 and k+3. A second hard case is a timing-word rewrite while a transfer is in flight. The same monitor fires that rewrite during the latch-enable cycle, so the in-flight transfer must keep the old timing and the next transfer must use the new one.

// File: rtl/pbseq_pkg.sv
package pbseq_pkg;

    localparam int A2W_W = 3;
    localparam int WRW_W = 4;
    localparam int IDL_W = 4;
    localparam int DLY_W = 2;
    localparam int CNT_W = (WRW_W > IDL_W) ? ((WRW_W > A2W_W) ? WRW_W : A2W_W)
                                           : ((IDL_W > A2W_W) ? IDL_W : A2W_W);

    localparam int BOOT_A2W = 7;
    localparam int BOOT_WRW = 7;
    localparam int BOOT_IDL = 6;
    localparam int DFLT_A2W = 1;
    localparam int DFLT_WRW = 1;
    localparam int DFLT_IDL = 1;
    localparam int DFLT_CSW = 3;

    typedef struct packed {
        logic             ack_en;
        logic             rdy_bypass;
        logic [DLY_W-1:0] cs_width;
        logic [DLY_W-1:0] oe2cs;
        logic [DLY_W-1:0] cs2oe;
        logic [IDL_W-1:0] idle;
        logic [WRW_W-1:0] wr_width;
        logic [A2W_W-1:0] ale2wr;
    } tcfg_t;

    localparam int CFG_W = $bits(tcfg_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE,
        ST_SETUP,
        ST_STRB,
        ST_RELS,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/pbseq_cfg_regs.sv
module pbseq_cfg_regs
    import pbseq_pkg::*;
#(
    parameter  int NREG = 8,
    localparam int RW   = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [RW-1:0]   sel,
    input  tcfg_t           wdata,
    input  logic [RW-1:0]   rd_sel,
    output tcfg_t           rd_cfg,
    output logic [NREG-1:0] err
);

    tcfg_t regs [NREG];

    function automatic tcfg_t rst_word(input int idx);
        tcfg_t w;
        w          = '0;
        w.ale2wr   = (idx == 0) ? A2W_W'(BOOT_A2W) : A2W_W'(DFLT_A2W);
        w.wr_width = (idx == 0) ? WRW_W'(BOOT_WRW) : WRW_W'(DFLT_WRW);
        w.idle     = (idx == 0) ? IDL_W'(BOOT_IDL) : IDL_W'(DFLT_IDL);
        w.cs_width = DLY_W'(DFLT_CSW);
        return w;
    endfunction

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= rst_word(i);
            end else if (we && sel == RW'(i)) begin
                regs[i] <= wdata;
            end
        end

        assign err[i] = (regs[i].cs2oe >= regs[i].cs_width);

        // R2: selected word takes the whole new value, others hold
        p_cfg_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == RW'(i)) |=> (regs[i] == $past(wdata)));
        p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && sel == RW'(i)) |=> $stable(regs[i]));
    end

    assign rd_cfg = regs[rd_sel];

endmodule

// File: rtl/pbseq_rdy_sync.sv
module pbseq_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    input  logic bypass,
    output logic rdy_eff
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rdy_async};
        end
    end

    assign rdy_eff = bypass ? rdy_async : chain_q[STAGES-1];

endmodule

// File: rtl/pbseq_top.sv
module pbseq_top
    import pbseq_pkg::*;
#(
    parameter  int NREG        = 8,
    parameter  int BUS_W       = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int RW          = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [RW-1:0]    cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [NREG-1:0]  cfg_err,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [RW-1:0]    req_region,
    input  logic             req_write,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    output logic             rsp_done,
    output logic [BUS_W-1:0] rsp_rdata,
    output logic             bus_ale,
    output logic             bus_cs_n,
    output logic             bus_oe_n,
    output logic             bus_we_n,
    output logic [BUS_W-1:0] bus_ad_o,
    output logic             bus_ad_oe,
    input  logic [BUS_W-1:0] bus_ad_i,
    input  logic             bus_rdy
);

    seq_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    tcfg_t            cur_q, sel_cfg;
    logic             wr_q;
    logic [BUS_W-1:0] addr_q, wdat_q;
    logic             rdy_eff;
    logic [CNT_W-1:0] lead_len, strb_len, rel_len;
    logic             strb_end, fin;

    pbseq_cfg_regs #(.NREG(NREG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (tcfg_t'(cfg_wdata)),
        .rd_sel (req_region),
        .rd_cfg (sel_cfg),
        .err    (cfg_err)
    );

    pbseq_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_async (bus_rdy),
        .bypass    (cur_q.rdy_bypass),
        .rdy_eff   (rdy_eff)
    );

    // phase lengths from the word latched at acceptance
    always_comb begin
        if (wr_q) begin
            lead_len = CNT_W'(cur_q.ale2wr);
            strb_len = (cur_q.wr_width == '0) ? CNT_W'(1) : CNT_W'(cur_q.wr_width);
        end else begin
            lead_len = CNT_W'(cur_q.cs2oe);
            strb_len = (cur_q.cs_width > cur_q.cs2oe) ?
                       CNT_W'(cur_q.cs_width - cur_q.cs2oe) : CNT_W'(1);
        end
        rel_len  = (!wr_q || cur_q.ack_en) ? CNT_W'(cur_q.oe2cs) : '0;
        strb_end = (cnt_q == '0) || (cur_q.ack_en && rdy_eff);
        fin      = ((st_q == ST_STRB) && strb_end && (rel_len == '0)) ||
                   ((st_q == ST_RELS) && (cnt_q == '0));
    end

    // next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) st_d = ST_ALE;
            end
            ST_ALE: begin
                if (lead_len != '0) begin
                    st_d  = ST_SETUP;
                    cnt_d = lead_len - CNT_W'(1);
                end else begin
                    st_d  = ST_STRB;
                    cnt_d = strb_len - CNT_W'(1);
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    st_d  = ST_STRB;
                    cnt_d = strb_len - CNT_W'(1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_STRB: begin
                if (strb_end) begin
                    st_d  = ST_RELS;
                    cnt_d = rel_len - CNT_W'(1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RELS: begin
                cnt_d = cnt_q - CNT_W'(1);
            end
            ST_GAP: begin
                if (cnt_q == '0) st_d = ST_IDLE;
                else             cnt_d = cnt_q - CNT_W'(1);
            end
            default: st_d = ST_IDLE;
        endcase
        if (fin) begin
            st_d  = (cur_q.idle != '0) ? ST_GAP : ST_IDLE;
            cnt_d = CNT_W'(cur_q.idle) - CNT_W'(1);
        end
    end

    // state register and transfer context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            cur_q     <= '0;
            wr_q      <= 1'b0;
            addr_q    <= '0;
            wdat_q    <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            st_q     <= st_d;
            cnt_q    <= cnt_d;
            rsp_done <= fin;
            if (st_q == ST_IDLE && req_valid) begin
                cur_q  <= sel_cfg;
                wr_q   <= req_write;
                addr_q <= req_addr;
                wdat_q <= req_wdata;
            end
            if (st_q == ST_STRB && strb_end && !wr_q) begin
                rsp_rdata <= bus_ad_i;
            end
        end
    end

    // bus outputs decoded from state
    always_comb begin
        req_ready = (st_q == ST_IDLE);
        bus_ale   = (st_q == ST_ALE);
        bus_cs_n  = !(st_q inside {ST_SETUP, ST_STRB, ST_RELS});
        bus_oe_n  = !((st_q == ST_STRB) && !wr_q);
        bus_we_n  = !((st_q == ST_STRB) && wr_q);
        bus_ad_oe = bus_ale || (wr_q && !bus_cs_n);
        bus_ad_o  = bus_ale ? addr_q : wdat_q;
    end

    // R12: strobes exclusive and inside chip select
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n));
    p_strobe_in_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);
    // R3: latch enable is a single cycle followed by chip select
    p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> (!bus_ale && !bus_cs_n));
    // R11: no acceptance while the bus is busy
    p_busy_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n || bus_ale) |-> !req_ready);
    // R5: completion pulse only right after chip select release
    p_done_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (bus_cs_n && $past(!bus_cs_n)));
    // R7: a seen acknowledge ends the strobe at that edge
    p_ack_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_oe_n) && cur_q.ack_en && rdy_eff |=> (bus_we_n && bus_oe_n));

endmodule

// File: tb/sim_pbseq_top.sv
module sim_pbseq_top;
    import pbseq_pkg::*;

    localparam int NREG = 8;
    localparam int BW   = 16;
    localparam int RW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             cfg_we, t_we, m_we;
    logic [RW-1:0]    cfg_sel, t_sel, m_sel;
    logic [CFG_W-1:0] cfg_wdata, t_wdata, m_wdata;
    logic [NREG-1:0]  cfg_err;
    logic             req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [RW-1:0]    req_region = '0;
    logic [BW-1:0]    req_addr = '0, req_wdata = '0;
    logic             rsp_done;
    logic [BW-1:0]    rsp_rdata;
    logic             bus_ale, bus_cs_n, bus_oe_n, bus_we_n, bus_ad_oe;
    logic [BW-1:0]    bus_ad_o;
    logic [BW-1:0]    bus_ad_i = '0;
    logic             bus_rdy = 1'b0;

    assign cfg_we    = t_we | m_we;
    assign cfg_sel   = m_we ? m_sel : t_sel;
    assign cfg_wdata = m_we ? m_wdata : t_wdata;

    pbseq_top #(.NREG(NREG), .BUS_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_ready(req_ready), .req_region(req_region),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_rdy(bus_rdy)
    );

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    tcfg_t model [NREG];

    // monitor state
    bit mon_on = 0, mid_on = 0;
    int ale_t, ale_n, cs_first, cs_last, st_first, st_n, kind, adbad, busyr;
    logic [BW-1:0] ale_addr, cur_wd;
    int rdy_mode = 0, ack_k = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    always @(negedge clk) begin
        if (mon_on) begin
            bit strobe;
            strobe = !bus_oe_n || !bus_we_n;
            if (bus_ale) begin
                if (ale_n == 0) begin ale_t = cyc; ale_addr = bus_ad_o; end
                ale_n++;
                if (!bus_ad_oe) adbad++;
            end
            if (!bus_cs_n) begin
                if (cs_first < 0) cs_first = cyc;
                cs_last = cyc;
            end
            if ((!bus_cs_n || bus_ale) && req_ready) busyr++;
            if (strobe) begin
                if (st_first < 0) st_first = cyc;
                st_n++;
                kind = kind | (!bus_oe_n ? 2 : 0) | (!bus_we_n ? 1 : 0);
                if (!bus_we_n && (bus_ad_o !== cur_wd || !bus_ad_oe)) adbad++;
                if (!bus_oe_n && bus_ad_oe) adbad++;
            end
            case (rdy_mode)
                1: bus_rdy = strobe && ((st_n - 1) >= ack_k);
                2: bus_rdy = 1'b1;
                3: bus_rdy = !strobe && (st_first < 0);
                default: bus_rdy = 1'b0;
            endcase
            if (mid_on && bus_ale) begin
                m_we = 1'b1;
            end else begin
                m_we = 1'b0;
            end
        end else begin
            m_we = 1'b0;
        end
    end

    task automatic set_cfg(input int r, input tcfg_t c);
        logic [NREG-1:0] exp_err;
        @(negedge clk);
        t_we = 1'b1; t_sel = RW'(r); t_wdata = c;
        @(negedge clk);
        t_we = 1'b0;
        model[r] = c;
        for (int i = 0; i < NREG; i++) exp_err[i] = (model[i].cs2oe >= model[i].cs_width);
        chk("R10 cfg_err vector", int'(cfg_err), int'(exp_err));
    endtask

    task automatic xfer(input int r, input bit wr, input logic [BW-1:0] addr,
                        input logic [BW-1:0] wd, input logic [BW-1:0] rd, input string tag);
        tcfg_t c;
        int acc_t, done_t, g, lead, slen, rel, guard, capped;
        c = model[r];
        ale_n = 0; cs_first = -1; cs_last = -1; st_first = -1; st_n = 0;
        kind = 0; adbad = 0; busyr = 0; cur_wd = wd; bus_ad_i = rd;
        @(negedge clk);
        mon_on = 1;
        req_valid = 1'b1; req_region = RW'(r); req_write = wr; req_addr = addr; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        acc_t = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_done && guard < 300) begin @(negedge clk); guard++; end
        done_t = cyc;
        if (!wr) chk("R4 read data", int'(rsp_rdata), int'(rd));
        g = 0;
        while (!req_ready && g < 100) begin g++; @(negedge clk); end
        mon_on = 0;
        bus_rdy = 1'b0;
        // expected timing
        if (wr) begin
            lead = c.ale2wr;
            slen = (c.wr_width == 0) ? 1 : int'(c.wr_width);
        end else begin
            lead = c.cs2oe;
            slen = (c.cs_width > c.cs2oe) ? int'(c.cs_width) - int'(c.cs2oe) : 1;
        end
        if (c.ack_en && rdy_mode == 1) begin
            capped = ack_k + 1 + (c.rdy_bypass ? 0 : 2);
            if (capped < slen) slen = capped;
        end
        rel = (!wr || c.ack_en) ? int'(c.oe2cs) : 0;
        chk("R3 ale cycle", ale_t, acc_t + 1);
        chk("R3 ale count", ale_n, 1);
        chk("R3 ale address", int'(ale_addr), int'(addr));
        chk("R3 cs start", cs_first, acc_t + 2);
        chk(wr ? "R3 strobe start" : "R4 strobe start", st_first, acc_t + 2 + lead);
        chk({tag, " strobe length"}, st_n, slen);
        chk("R5 cs release", cs_last, acc_t + 2 + lead + slen - 1 + rel);
        chk("R5 done cycle", done_t, acc_t + 3 + lead + slen - 1 + rel);
        chk("R6 idle window", g, int'(c.idle));
        chk("R12 strobe kind", kind, wr ? 1 : 2);
        chk("R12 bus drive", adbad, 0);
        chk("R11 ready while busy", busyr, 0);
    endtask

    initial begin
        tcfg_t c;
        t_we = 1'b0; t_sel = '0; t_wdata = '0;
        m_sel = '0; m_wdata = '0;
        for (int i = 0; i < NREG; i++) begin
            c = '0;
            c.ale2wr = (i == 0) ? 3'd7 : 3'd1;
            c.wr_width = (i == 0) ? 4'd7 : 4'd1;
            c.idle = (i == 0) ? 4'd6 : 4'd1;
            c.cs_width = 2'd3;
            model[i] = c;
        end
        repeat (3) @(negedge clk);
        chk("R1 reset ready", int'(req_ready), 1);
        chk("R1 reset cs_n", int'(bus_cs_n), 1);
        chk("R1 reset strobes", int'({bus_ale, bus_oe_n, bus_we_n}), 3);
        chk("R1 reset done", int'(rsp_done), 0);
        chk("R10 reset cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset timing words
        xfer(0, 1, 16'h1000, 16'hA5A5, 16'h0, "R1");
        xfer(3, 1, 16'h1234, 16'h5A5A, 16'h0, "R1");
        xfer(0, 0, 16'h2000, 16'h0, 16'hBEEF, "R1");
        xfer(6, 0, 16'h2468, 16'h0, 16'hC0DE, "R1");

        // R3 write sweep
        for (int a = 0; a < 8; a++) begin
            for (int w = 0; w < 16; w++) begin
                c = '0;
                c.ale2wr = 3'(a); c.wr_width = 4'(w); c.idle = 4'((a * 5 + w) % 16);
                c.oe2cs = 2'(w % 4); c.cs2oe = 2'(a % 4); c.cs_width = 2'd3;
                c.rdy_bypass = 1'(a % 2);
                set_cfg((a + w) % 8, c);
                xfer((a + w) % 8, 1, 16'(a * 256 + w), 16'(16'h3C00 + a * 17 + w), 16'h0, "R3");
            end
        end

        // R4 read sweep, includes invalid OE delay cases (R10)
        for (int co = 0; co < 4; co++) begin
            for (int cw = 0; cw < 4; cw++) begin
                for (int oe = 0; oe < 4; oe++) begin
                    c = '0;
                    c.cs2oe = 2'(co); c.cs_width = 2'(cw); c.oe2cs = 2'(oe);
                    c.idle = 4'(oe + cw); c.ale2wr = 3'(co);
                    set_cfg((co * 4 + cw) % 8, c);
                    xfer((co * 4 + cw) % 8, 0, 16'(co * 64 + cw * 8 + oe),
                         16'h0, 16'(16'h8000 + co * 100 + cw * 10 + oe), "R4");
                end
            end
        end

        // R2: rewrite one region, others keep their words
        c = '0; c.ale2wr = 3'd2; c.wr_width = 4'd3; c.idle = 4'd2; c.cs_width = 2'd2;
        set_cfg(1, c);
        xfer(1, 1, 16'h0101, 16'h1111, 16'h0, "R2");
        xfer(2, 1, 16'h0202, 16'h2222, 16'h0, "R2");
        xfer(7, 0, 16'h0707, 16'h0, 16'h7777, "R2");

        // R7/R8: acknowledge at strobe cycle k, synchronized and bypassed
        rdy_mode = 1;
        for (int byp = 0; byp < 2; byp++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int k = 0; k < 6; k++) begin
                    c = '0;
                    c.ack_en = 1'b1; c.rdy_bypass = 1'(byp);
                    c.ale2wr = 3'd2; c.wr_width = 4'd9; c.cs_width = 2'd3;
                    c.oe2cs = 2'(k % 4); c.idle = 4'd1;
                    set_cfg(5, c);
                    ack_k = k;
                    xfer(5, 1'(wr), 16'(k), 16'(16'h4400 + k), 16'(16'h9900 + k),
                         byp ? "R8 bypass" : "R7 R8 sync");
                end
            end
        end

        // R9: ready ignored when acknowledge off, or outside the strobe
        rdy_mode = 2;
        c = '0; c.ale2wr = 3'd1; c.wr_width = 4'd5; c.cs_width = 2'd3; c.idle = 4'd1;
        set_cfg(4, c);
        xfer(4, 1, 16'h0404, 16'h4444, 16'h0, "R9 ack off");
        xfer(4, 0, 16'h0405, 16'h0, 16'h4545, "R9 ack off");
        rdy_mode = 3;
        c = '0; c.ack_en = 1'b1; c.rdy_bypass = 1'b1; c.ale2wr = 3'd3;
        c.wr_width = 4'd6; c.cs2oe = 2'd1; c.cs_width = 2'd3; c.idle = 4'd2;
        set_cfg(4, c);
        xfer(4, 1, 16'h0406, 16'h4646, 16'h0, "R9 outside strobe");
        xfer(4, 0, 16'h0407, 16'h0, 16'h4747, "R9 outside strobe");
        rdy_mode = 0;

        // R11: word rewritten during transfer does not affect it
        c = '0; c.ale2wr = 3'd4; c.wr_width = 4'd6; c.idle = 4'd3; c.cs_width = 2'd3;
        set_cfg(6, c);
        c.ale2wr = 3'd1; c.wr_width = 4'd2; c.idle = 4'd5;
        m_sel = 3'd6; m_wdata = c;
        mid_on = 1;
        xfer(6, 1, 16'h0606, 16'h6666, 16'h0, "R11 in flight");
        mid_on = 0;
        model[6] = c;
        xfer(6, 1, 16'h0607, 16'h6767, 16'h0, "R11 next uses new");

        finish_up();
    end

endmodule